// File: doc/BRIEF.md
# SAR Converter Sequencer with Byte-Wide Bus

This block is the digital heart of a 10-bit successive-approximation converter with a byte-wide parallel bus. A host writes a configuration byte with a rising edge of the write strobe while chip select is low. That byte selects the power state, the conversion clock source, the acquisition style, single-ended or paired inputs, unipolar or bipolar coding, and the channel. The block then runs a track phase. The track phase is either timed internally or closed by a second write. The block then resolves the result one bit per conversion tick from a single comparator input bit. When the result is ready, it pulls an active-low interrupt. The host reads the result as a low byte and a high byte. The high byte carries the sign extension when the coding is bipolar.

The analog path stays outside this block. The block drives a trial code to the capacitive DAC and reads back a comparator bit. It also drives one-hot selects to the positive and negative input multiplexers, and a track flag to the track/hold. Conversion ticks come from two clock-enable inputs. One stands for the free-running on-chip oscillator. The other stands for edges of an externally supplied converter clock.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, int_no is 1 and data_oe_o is 0. pwr_mode_o is 0 (running), track_o is 0 and addr_err_o is 0. mux_pos_o selects channel 0 and mux_neg_o is all zero. The tick source is ext_tick_i.
- R2: A configuration byte is captured from data_i on a rising edge of wr_ni while cs_ni is low. Its fields are: bits 7:6 power code, bit 5 external-acquisition flag, bit 4 single-ended flag, bit 3 unipolar flag, bits 2:0 channel address.
- R3: A write with power code 1x and bit 5 = 0 sets track_o. After 4 ticks of the selected source, tracking ends and conversion starts. int_no falls on the 17th tick after the write.
- R4: A write with power code 1x and bit 5 = 1 keeps track_o high with no time limit. A following write with bit 5 = 0 and the same channel address starts conversion at once. int_no falls on the 13th tick after that write.
- R5: If the closing write carries a different channel address, addr_err_o is set and stays set until reset. The block then restarts as an internally timed acquisition (17 ticks to int_no low).
- R6: A conversion takes 13 ticks and tests bits MSB first. It keeps a trial bit when cmp_i is 1 (sampled value at or above the trial code on dac_code_o). In unipolar mode the result is straight binary. In bipolar mode it is two's complement, formed by inverting the MSB.
- R7: A write during a conversion aborts it. The new byte starts a new acquisition, and only the new result is ever reported.
- R8: int_no stays low until a read falling edge with cs_ni low or a write rising edge with cs_ni low, and either one returns it to 1.
- R9: While hben_i is 0, data_o carries result bits 7:0. While hben_i is 1, data_o[1:0] carries result bits 9:8. data_o[7:2] is then 0 in unipolar mode, or copies of result bit 9 in bipolar mode.
- R10: While cs_ni is 1, data_oe_o is 0, and ext_tick_i, wr_ni and rd_ni have no effect.
- R11: Power code 00 sets pwr_mode_o to 2 (off) and 01 sets it to 1 (standby). Neither changes the tick source, and neither starts an acquisition from idle. Any later write with power code 1x returns pwr_mode_o to 0.
- R12: Power code 10 selects int_tick_i as tick source and 11 selects ext_tick_i.
- R13: In single-ended mode mux_pos_o is one-hot at the channel address and mux_neg_o is zero. In paired mode mux_neg_o is one-hot at the address with its bit 0 inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low, acts on its rising edge |
| rd_ni | input | 1 | Read strobe, active low, acts on its falling edge |
| hben_i | input | 1 | Selects the high result byte on data_o |
| data_i | input | 8 | Configuration byte from the bus |
| data_o | output | 8 | Result byte to the bus |
| data_oe_o | output | 1 | Bus driver enable |
| int_no | output | 1 | Result ready, active low |
| ext_tick_i | input | 1 | One-cycle enable for each external converter clock edge |
| int_tick_i | input | 1 | One-cycle enable from the on-chip oscillator |
| cmp_i | input | 1 | Comparator: sampled value at or above trial code |
| dac_code_o | output | RES | Trial code to the capacitive DAC |
| track_o | output | 1 | Track/hold in track phase |
| mux_pos_o | output | NCH | One-hot positive input select |
| mux_neg_o | output | NCH | One-hot negative input select, zero selects common |
| pwr_mode_o | output | 2 | 0 running, 1 standby, 2 off |
| addr_err_o | output | 1 | Sticky channel-mismatch flag |

## Verification
The bench builds the block with its defaults: RES = 10, NCH = 8, ACQ_TICKS = 4 and CONV_TICKS = 13. These defaults make the 17-tick and 13-tick totals and the full eight-channel pair decode exact, observable targets. Because the high byte is two bits wide, six sign-copy positions can be checked against both result codings. Ticks on the two sources arrive at different rates, so a tick count that matches the expected total also proves which source was used. A behavioural comparator closes the loop through dac_code_o, so every result shows the whole bit-by-bit search.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_XACQ = 2'd2,
    ST_CONV = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_STBY = 2'd1,
    PWR_OFF  = 2'd2
  } pwr_mode_e;

  // bit order is decoded by the host, so it is fixed
  typedef struct packed {
    logic [1:0] pd;
    logic       acq_ext;
    logic       single;
    logic       unipolar;
    logic [2:0] addr;
  } ctrl_byte_t;

  function automatic pwr_mode_e pd_to_mode(input logic [1:0] pd);
    if (pd[1])      return PWR_RUN;
    else if (pd[0]) return PWR_STBY;
    else            return PWR_OFF;
  endfunction

endpackage

// File: rtl/sar_cfg_decode.sv
module sar_cfg_decode #(
  parameter int NCH = 8
) (
  input  logic [2:0]     addr_i,
  input  logic           single_i,
  output logic [NCH-1:0] pos_o,
  output logic [NCH-1:0] neg_o
);
  localparam int AW = $clog2(NCH);

  logic [AW-1:0] sel;
  logic [AW-1:0] mate;
  assign sel  = addr_i[AW-1:0];
  assign mate = sel ^ AW'(1);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign pos_o[i] = (sel == AW'(i));
    assign neg_o[i] = !single_i && (mate == AW'(i));
  end

  always_comb begin
    if (single_i) AST_SE_NEG_COM: assert (neg_o == '0); // R13
  end

endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int RES        = 10,
  parameter int CONV_TICKS = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           step_i,
  input  logic           cmp_i,
  output logic [RES-1:0] trial_o,
  output logic [RES-1:0] code_o,
  output logic           last_o
);
  localparam int CW = $clog2(CONV_TICKS);

  logic [CW-1:0]  cnt_q;
  logic [RES-1:0] sar_q;
  logic [RES-1:0] mask;

  for (genvar i = 0; i < RES; i++) begin : g_mask
    assign mask[i] = (cnt_q == CW'(RES - 1 - i));
  end

  assign trial_o = sar_q | mask;
  assign code_o  = sar_q;
  assign last_o  = step_i && (cnt_q == CW'(CONV_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sar_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sar_q <= '0;
    end else if (step_i) begin
      cnt_q <= last_o ? '0 : cnt_q + CW'(1);
      for (int i = 0; i < RES; i++) begin
        if (mask[i]) sar_q[i] <= cmp_i;
      end
    end
  end

  AST_SAR_SINGLE_TRIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trial_o ^ code_o)); // R6

  AST_SAR_TAIL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && cnt_q >= CW'(RES)) |=> $stable(sar_q)); // R6

endmodule

// File: rtl/sar_bus_fmt.sv
module sar_bus_fmt #(
  parameter int RES = 10
) (
  input  logic [RES-1:0] result_i,
  input  logic           bipolar_i,
  input  logic           hben_i,
  input  logic           cs_ni,
  input  logic           rd_ni,
  output logic [7:0]     data_o,
  output logic           data_oe_o
);
  localparam int HW = RES - 8;
  localparam int SW = 8 - HW;

  logic [7:0] hi_byte;
  assign hi_byte   = {{SW{bipolar_i & result_i[RES-1]}}, result_i[RES-1:8]};
  assign data_o    = hben_i ? hi_byte : result_i[7:0];
  assign data_oe_o = !cs_ni && !rd_ni;

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES        = 10,
  parameter int NCH        = 8,
  parameter int ACQ_TICKS  = 4,
  parameter int CONV_TICKS = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           wr_ni,
  input  logic           rd_ni,
  input  logic           hben_i,
  input  logic [7:0]     data_i,
  output logic [7:0]     data_o,
  output logic           data_oe_o,
  output logic           int_no,
  input  logic           ext_tick_i,
  input  logic           int_tick_i,
  input  logic           cmp_i,
  output logic [RES-1:0] dac_code_o,
  output logic           track_o,
  output logic [NCH-1:0] mux_pos_o,
  output logic [NCH-1:0] mux_neg_o,
  output logic [1:0]     pwr_mode_o,
  output logic           addr_err_o
);
  localparam int AQW = $clog2(ACQ_TICKS + 1);

  seq_state_e     state_q, state_d;
  logic [AQW-1:0] acq_q, acq_d;
  logic [2:0]     addr_q;
  logic           single_q, unip_q;
  logic           clk_ext_q;
  pwr_mode_e      pwr_q;
  logic           int_q, err_q;
  logic [RES-1:0] result_q;
  logic           res_bip_q;
  logic           wr_q, rd_q;

  ctrl_byte_t     nb;
  logic           wr_rise, rd_fall, tick;
  logic           closing, addr_ok;
  logic           enter_conv, conv_step, conv_last;
  logic [RES-1:0] code, final_code;

  assign nb      = ctrl_byte_t'(data_i);
  assign wr_rise = !cs_ni && wr_ni && !wr_q;
  assign rd_fall = !cs_ni && !rd_ni && rd_q;
  // external ticks pass only while selected
  assign tick    = clk_ext_q ? (ext_tick_i && !cs_ni) : int_tick_i;
  assign closing = (state_q == ST_XACQ) && !nb.acq_ext;
  assign addr_ok = (nb.addr == addr_q);

  always_comb begin
    state_d    = state_q;
    acq_d      = acq_q;
    enter_conv = 1'b0;
    if (wr_rise) begin
      acq_d = '0;
      if (closing && addr_ok) begin
        state_d    = ST_CONV;
        enter_conv = 1'b1;
      end else if (!nb.pd[1]) begin
        state_d = ST_IDLE;
      end else if (nb.acq_ext && !closing) begin
        state_d = ST_XACQ;
      end else begin
        state_d = ST_ACQ;
      end
    end else if (tick) begin
      unique case (state_q)
        ST_ACQ: begin
          if (acq_q == AQW'(ACQ_TICKS - 1)) begin
            state_d    = ST_CONV;
            enter_conv = 1'b1;
          end else begin
            acq_d = acq_q + AQW'(1);
          end
        end
        ST_CONV: if (conv_last) state_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  assign conv_step  = tick && !wr_rise && (state_q == ST_CONV);
  assign final_code = unip_q ? code : {~code[RES-1], code[RES-2:0]};

  sar_core #(
    .RES       (RES),
    .CONV_TICKS(CONV_TICKS)
  ) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (enter_conv),
    .step_i (conv_step),
    .cmp_i  (cmp_i),
    .trial_o(dac_code_o),
    .code_o (code),
    .last_o (conv_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      acq_q     <= '0;
      addr_q    <= '0;
      single_q  <= 1'b1;
      unip_q    <= 1'b1;
      clk_ext_q <= 1'b1;
      pwr_q     <= PWR_RUN;
      int_q     <= 1'b1;
      err_q     <= 1'b0;
      result_q  <= '0;
      res_bip_q <= 1'b0;
      wr_q      <= 1'b1;
      rd_q      <= 1'b1;
    end else begin
      state_q <= state_d;
      acq_q   <= acq_d;
      wr_q    <= wr_ni;
      rd_q    <= rd_ni;
      if (wr_rise) begin
        addr_q   <= nb.addr;
        single_q <= nb.single;
        unip_q   <= nb.unipolar;
        pwr_q    <= pd_to_mode(nb.pd);
        if (nb.pd[1]) clk_ext_q <= nb.pd[0];
        if (closing && !addr_ok) err_q <= 1'b1;
      end
      if (conv_last) begin
        result_q  <= final_code;
        res_bip_q <= !unip_q;
      end
      if (wr_rise)        int_q <= 1'b1;
      else if (conv_last) int_q <= 1'b0;
      else if (rd_fall)   int_q <= 1'b1;
    end
  end

  sar_cfg_decode #(
    .NCH(NCH)
  ) u_dec (
    .addr_i  (addr_q),
    .single_i(single_q),
    .pos_o   (mux_pos_o),
    .neg_o   (mux_neg_o)
  );

  sar_bus_fmt #(
    .RES(RES)
  ) u_fmt (
    .result_i (result_q),
    .bipolar_i(res_bip_q),
    .hben_i   (hben_i),
    .cs_ni    (cs_ni),
    .rd_ni    (rd_ni),
    .data_o   (data_o),
    .data_oe_o(data_oe_o)
  );

  assign int_no     = int_q;
  assign track_o    = (state_q == ST_ACQ) || (state_q == ST_XACQ);
  assign pwr_mode_o = pwr_q;
  assign addr_err_o = err_q;

  AST_WR_RELEASES_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rise |=> int_no); // R8

  AST_RD_RELEASES_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fall && !conv_last) |=> int_no); // R8

  AST_ABORT_LEAVES_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rise && state_q == ST_CONV) |=> (state_q != ST_CONV)); // R7

  AST_INT_AFTER_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_no) |-> $past(state_q == ST_CONV)); // R6

  AST_PD_KEEPS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rise && !data_i[7]) |=> $stable(clk_ext_q)); // R11

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |=> addr_err_o); // R5

  AST_CS_FREEZES_XACQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && state_q == ST_XACQ) |=> (state_q == ST_XACQ)); // R10

endmodule

// File: tb/sar_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b0, wr_ni = 1'b1, rd_ni = 1'b1, hben_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] data_o;
  logic       data_oe, int_no, track, addr_err;
  logic       ext_tick = 1'b0, int_tick = 1'b0;
  logic [9:0] dac_code;
  logic [9:0] vin = '0;
  logic [7:0] mux_pos, mux_neg;
  logic [1:0] pwr_mode;
  logic       cmp;

  int n_chk = 0, n_fail = 0;
  int ediv = 0, idiv = 0;
  logic [15:0] exp_q[$];
  bit mon_en = 1'b1, mon_busy = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    ediv     <= (ediv == 3) ? 0 : ediv + 1;
    ext_tick <= (ediv == 3);
    idiv     <= (idiv == 5) ? 0 : idiv + 1;
    int_tick <= (idiv == 5);
  end

  assign cmp = (dac_code <= vin);

  sar_adc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni), .rd_ni(rd_ni),
    .hben_i(hben_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe),
    .int_no(int_no), .ext_tick_i(ext_tick), .int_tick_i(int_tick), .cmp_i(cmp),
    .dac_code_o(dac_code), .track_o(track), .mux_pos_o(mux_pos),
    .mux_neg_o(mux_neg), .pwr_mode_o(pwr_mode), .addr_err_o(addr_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_bytes(input logic [9:0] v, input bit bip);
    logic [9:0] e;
    logic [7:0] hi;
    e  = bip ? (v ^ 10'h200) : v;
    hi = bip ? {{6{e[9]}}, e[9:8]} : {6'b0, e[9:8]};
    return {hi, e[7:0]};
  endfunction

  task automatic do_write(input logic [7:0] b);
    data_i = b;
    wr_ni  = 1'b0;
    @(negedge clk);
    wr_ni  = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_byte(input bit hb, output logic [7:0] b);
    hben_i = hb;
    rd_ni  = 1'b0;
    @(negedge clk);
    b      = data_o;
    rd_ni  = 1'b1;
    @(negedge clk);
  endtask

  task automatic count_ticks(input bit use_int, output int n);
    n = 0;
    while (int_no && n < 200) begin
      if (use_int ? int_tick : (ext_tick && !cs_ni)) n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_ticks(input int k);
    int n = 0;
    while (n < k) begin
      if (ext_tick && !cs_ni) n++;
      @(negedge clk);
    end
  endtask

  task automatic push(input logic [9:0] v, input bit bip);
    vin = v;
    exp_q.push_back(exp_bytes(v, bip));
  endtask

  task automatic wait_done();
    forever begin
      @(negedge clk);
      if (exp_q.size() == 0 && !mon_busy && int_no) break;
    end
  endtask

  // monitor: pops expected results as interrupts appear
  initial begin
    logic [7:0]  lo, hi;
    logic [15:0] e;
    forever begin
      @(negedge clk);
      if (mon_en && rst_ni && !int_no) begin
        mon_busy = 1'b1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected result", 1, 0);
          e = '0;
        end else begin
          e = exp_q.pop_front();
        end
        rd_byte(1'b0, lo);
        rd_byte(1'b1, hi);
        check(lo == e[7:0], "R6 low byte", lo, e[7:0]);
        check(hi == e[15:8], "R9 high byte", hi, e[15:8]);
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] b;
    bit oe_seen;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(int_no == 1'b1, "R1 int_no", int_no, 1);
    check(data_oe == 1'b0, "R1 data_oe", data_oe, 0);
    check(pwr_mode == 2'd0 && track == 1'b0 && addr_err == 1'b0, "R1 state",
          {pwr_mode, track, addr_err}, 0);
    check(mux_pos == 8'h01 && mux_neg == 8'h00, "R1 mux", {mux_pos, mux_neg}, 16'h0100);

    // R3 R2 R12: internal acquisition on default external ticks
    push(10'h2A5, 1'b0);
    do_write(8'hDB);
    check(track == 1'b1, "R3 track after write", track, 1);
    check(mux_pos == 8'h08 && mux_neg == 8'h00, "R13 single-ended mux",
          {mux_pos, mux_neg}, 16'h0800);
    count_ticks(1'b0, n);
    check(n == 17, "R3 ticks to result", n, 17);
    wait_done();

    // R4 external acquisition
    do_write(8'hFD);
    repeat (40) @(negedge clk);
    check(track == 1'b1 && int_no == 1'b1, "R4 open track", {track, int_no}, 3);
    push(10'h0F0, 1'b0);
    do_write(8'hDD);
    check(track == 1'b0, "R4 closing write holds", track, 0);
    count_ticks(1'b0, n);
    check(n == 13, "R4 ticks to result", n, 13);
    wait_done();

    // R13 paired inputs
    do_write(8'hED);
    check(mux_pos == 8'h20 && mux_neg == 8'h10, "R13 paired mux",
          {mux_pos, mux_neg}, 16'h2010);
    push(10'h3FE, 1'b0);
    do_write(8'hCD);
    count_ticks(1'b0, n);
    check(n == 13, "R4 paired close", n, 13);
    wait_done();

    // R7 abort mid-conversion
    vin = 10'h111;
    do_write(8'hDB);
    wait_ticks(8);
    check(track == 1'b0, "R7 in conversion", track, 0);
    push(10'h3C3, 1'b0);
    do_write(8'hDB);
    count_ticks(1'b0, n);
    check(n == 17, "R7 restart ticks", n, 17);
    wait_done();

    // R9 R6 bipolar and unipolar extremes
    push(10'h005, 1'b1); do_write(8'hD3); wait_done();
    push(10'h3FF, 1'b1); do_write(8'hD3); wait_done();
    push(10'h200, 1'b1); do_write(8'hD3); wait_done();
    push(10'h000, 1'b0); do_write(8'hDB); wait_done();
    push(10'h3FF, 1'b0); do_write(8'hDB); wait_done();

    // R10 chip select high freezes ticks, writes and reads
    push(10'h155, 1'b0);
    do_write(8'hDB);
    fork
      count_ticks(1'b0, n);
      begin
        repeat (20) @(negedge clk);
        cs_ni = 1'b1;
        @(negedge clk);
        rd_ni = 1'b0;
        wr_ni = 1'b0;
        data_i = 8'h1B;
        @(negedge clk);
        oe_seen = data_oe;
        rd_ni = 1'b1;
        wr_ni = 1'b1;
        repeat (60) @(negedge clk);
        cs_ni = 1'b0;
      end
    join
    check(oe_seen == 1'b0, "R10 bus off", oe_seen, 0);
    check(n == 17, "R10 ticks ignored", n, 17);
    check(pwr_mode == 2'd0, "R10 write ignored", pwr_mode, 0);
    wait_done();

    // R8 interrupt release
    mon_en = 1'b0;
    vin = 10'h0AA;
    do_write(8'hDB);
    count_ticks(1'b0, n);
    repeat (20) @(negedge clk);
    check(int_no == 1'b0, "R8 int held", int_no, 0);
    rd_byte(1'b0, b);
    check(int_no == 1'b1, "R8 read releases", int_no, 1);
    check(b == 8'hAA, "R8 read data", b, 8'hAA);
    do_write(8'hDB);
    count_ticks(1'b0, n);
    check(int_no == 1'b0, "R8 int low again", int_no, 0);
    do_write(8'hFD);
    check(int_no == 1'b1, "R8 write releases", int_no, 1);
    mon_en = 1'b1;
    push(10'h07E, 1'b0);
    do_write(8'hDD);
    wait_done();

    // R12 internal tick source, R11 power codes
    push(10'h321, 1'b0);
    do_write(8'h9B);
    count_ticks(1'b1, n);
    check(n == 17, "R12 internal ticks", n, 17);
    check(pwr_mode == 2'd0, "R11 running", pwr_mode, 0);
    wait_done();
    do_write(8'hBB);
    push(10'h0C8, 1'b0);
    do_write(8'h1B);
    check(pwr_mode == 2'd2, "R11 off code", pwr_mode, 2);
    count_ticks(1'b1, n);
    check(n == 13, "R11 clock source kept", n, 13);
    wait_done();
    do_write(8'h5B);
    check(pwr_mode == 2'd1 && track == 1'b0, "R11 standby no acquisition",
          {pwr_mode, track}, 2);
    repeat (40) @(negedge clk);
    check(int_no == 1'b1, "R11 no conversion", int_no, 1);
    push(10'h199, 1'b0);
    do_write(8'hDB);
    check(pwr_mode == 2'd0 && track == 1'b1, "R11 wake", {pwr_mode, track}, 1);
    wait_done();

    // R5 address mismatch on closing write
    do_write(8'hFD);
    push(10'h246, 1'b0);
    do_write(8'hDC);
    check(addr_err == 1'b1 && track == 1'b1, "R5 flag and restart",
          {addr_err, track}, 3);
    check(mux_pos == 8'h10, "R5 new channel", mux_pos, 8'h10);
    count_ticks(1'b0, n);
    check(n == 17, "R5 internal timing", n, 17);
    wait_done();
    push(10'h013, 1'b0);
    do_write(8'hDB);
    check(addr_err == 1'b1, "R5 sticky", addr_err, 1);
    wait_done();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule